// File: doc/BRIEF.md
# Time-Slotted Bus Arbiter with Round-Robin Reuse

This block decides which of several initiators owns a shared bus. A wheel of time slots, held in a slot table that can be written at run time, reserves bandwidth. Each table entry either names an owning initiator or is marked free. When the wheel reaches an owned slot and the owner is requesting, the owner wins the bus. If the owner is silent, or the slot is free, the slot is not wasted. It goes to a rotating round-robin choice among whichever initiators are requesting. Reserved bandwidth for time-critical links therefore sits beside contention-based service for all other traffic.

A grant opens a transfer window whose length in bus cycles comes from a latency setting, limited to the range 2 to 7. The one-hot grant stays constant for the whole window. A strobe marks the window's final cycle. After the window closes, the arbiter spends one cycle with no grant, then arbitrates the next slot. When nobody requests, an arbitration cycle stays idle and the wheel still moves on by one slot.

Top module: `tdma_rr_arbiter`

## Requirements
- R1: During and right after a synchronous active-high reset, `grant` and `win_last` are zero and every slot-table entry is free. The slot pointer and the round-robin pointer both start at 0.
- R2: In an arbitration cycle, if the entry under the slot pointer is owned and its owner's `req` bit is high, the next cycle grants that owner, whatever the round-robin pointer holds.
- R3: In an arbitration cycle, if the entry is free or its owner is not requesting, and any `req` bit is high, the grant goes to the first requesting initiator found by searching upward from the round-robin pointer and wrapping past the highest index.
- R4: A grant won by contention moves the round-robin pointer to the winner's index plus one, wrapping to 0. A grant won by a slot owner leaves the round-robin pointer unchanged.
- R5: A grant stays asserted and unchanged for exactly L cycles. L is `lat_cfg` sampled in the arbitration cycle, with values below 2 taken as 2 and values above 7 taken as 7. The cycle after the window always has `grant` zero.
- R6: `win_last` is high exactly in the final cycle of each grant window and low in every other cycle.
- R7: `grant` is always one-hot or all zero.
- R8: The slot pointer moves to the next entry after every completed grant window and after every arbitration cycle with no request. It wraps from the last entry to entry 0.
- R9: When `map_we` is high, entry `map_idx` takes `map_valid` (1 = owned) and `map_owner` at the clock edge. Arbitration in that same cycle still uses the old content. A write never disturbs a grant window already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N_INIT | Request line per initiator |
| map_we | input | 1 | Slot-table write enable |
| map_idx | input | SLOT_W | Slot-table entry to write |
| map_valid | input | 1 | 1 marks the entry as owned, 0 as free |
| map_owner | input | ID_W | Owning initiator index for the entry |
| lat_cfg | input | LAT_W | Requested transfer window length in cycles |
| grant | output | N_INIT | One-hot grant, held for the window |
| win_last | output | 1 | High in the last cycle of a grant window |

## Verification
The interesting overlap is a slot-table write that lands in the same cycle the arbiter reads that entry, or one cycle before the pointer reaches it. Only the second case may change the winner. Both are provoked two ways: by a directed write to the entry the pointer is about to visit, and by a long pseudo-random run that mixes writes, requests and out-of-range latency settings. A cycle-level model in the bench, built from the requirements, predicts every grant, including whether the old or the new entry decided it. A second overlap, a window closing while new requests arrive, is judged in the same way: the bench expects one idle grant cycle before the next slot.

// File: rtl/tdma_arb_pkg.sv
package tdma_arb_pkg;

    localparam int unsigned LAT_MIN = 2;
    localparam int unsigned LAT_MAX = 7;

    typedef enum logic {
        ST_ARB  = 1'b0,
        ST_XFER = 1'b1
    } arb_state_e;

    typedef logic [2:0] lat_t;

    // Limit a raw latency request to the supported window lengths.
    function automatic lat_t clamp_lat(input logic [7:0] raw);
        if (raw < 8'(LAT_MIN))      return lat_t'(LAT_MIN);
        else if (raw > 8'(LAT_MAX)) return lat_t'(LAT_MAX);
        else                        return raw[2:0];
    endfunction

endpackage

// File: rtl/tdma_slot_table.sv
module tdma_slot_table #(
    parameter  int N_SLOTS = 8,
    parameter  int ID_W    = 2,
    localparam int SLOT_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  logic              wr_valid,
    input  logic [ID_W-1:0]   wr_owner,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic              rd_valid,
    output logic [ID_W-1:0]   rd_owner
);

    logic [N_SLOTS-1:0] vld_w;
    logic [ID_W-1:0]    own_w [N_SLOTS];

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_entry
        logic            v_q;
        logic [ID_W-1:0] o_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                o_q <= '0;
            end else if (wr_en && (wr_idx == SLOT_W'(g))) begin
                v_q <= wr_valid;
                o_q <= wr_owner;
            end
        end

        assign vld_w[g] = v_q;
        assign own_w[g] = o_q;
    end

    assign rd_valid = vld_w[rd_idx];
    assign rd_owner = own_w[rd_idx];

    // R9
    wr_land_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (vld_w[$past(wr_idx)] == $past(wr_valid)) &&
                  (own_w[$past(wr_idx)] == $past(wr_owner)));

    // R1
    rst_free_chk: assert property (@(posedge clk)
        $past(rst) |-> (vld_w == '0));

endmodule

// File: rtl/tdma_rr_pick.sv
module tdma_rr_pick #(
    parameter int N_INIT = 4,
    parameter int ID_W   = 2
) (
    input  logic [N_INIT-1:0] req,
    input  logic [ID_W-1:0]   base,
    output logic              any,
    output logic [ID_W-1:0]   win
);

    // Circular search upward from base.
    always_comb begin
        any = 1'b0;
        win = '0;
        for (int k = 0; k < N_INIT; k++) begin
            int idx;
            idx = int'(base) + k;
            if (idx >= N_INIT) idx = idx - N_INIT;
            if (!any && req[idx]) begin
                any = 1'b1;
                win = ID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/tdma_lat_timer.sv
module tdma_lat_timer
    import tdma_arb_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LAT_W-1:0] lat_cfg,
    output logic             last
);

    lat_t cnt_q;
    lat_t len;

    always_comb len = clamp_lat(8'(lat_cfg));

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= len - 3'd1;
        else if (cnt_q != '0) cnt_q <= cnt_q - 3'd1;
    end

    assign last = (cnt_q == '0);

    // R5
    lat_range_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q >= 3'(LAT_MIN - 1)) && (cnt_q <= 3'(LAT_MAX - 1)));

endmodule

// File: rtl/tdma_rr_arbiter.sv
module tdma_rr_arbiter
    import tdma_arb_pkg::*;
#(
    parameter  int N_INIT  = 4,
    parameter  int N_SLOTS = 8,
    parameter  int LAT_W   = 4,
    localparam int ID_W    = (N_INIT > 1) ? $clog2(N_INIT) : 1,
    localparam int SLOT_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_INIT-1:0] req,
    input  logic              map_we,
    input  logic [SLOT_W-1:0] map_idx,
    input  logic              map_valid,
    input  logic [ID_W-1:0]   map_owner,
    input  logic [LAT_W-1:0]  lat_cfg,
    output logic [N_INIT-1:0] grant,
    output logic              win_last
);

    arb_state_e        st_q;
    logic [N_INIT-1:0] gnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic [ID_W-1:0]   rr_q;

    logic              ent_v;
    logic [ID_W-1:0]   ent_o;
    logic              rr_any;
    logic [ID_W-1:0]   rr_win;
    logic              tmr_last;

    logic              arb_phase;
    logic              own_ok;
    logic              own_hit;
    logic              contend;
    logic              go;
    logic [ID_W-1:0]   win;
    logic [SLOT_W-1:0] slot_nx;
    logic [ID_W-1:0]   rr_nx;

    tdma_slot_table #(.N_SLOTS(N_SLOTS), .ID_W(ID_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (map_we),
        .wr_idx   (map_idx),
        .wr_valid (map_valid),
        .wr_owner (map_owner),
        .rd_idx   (slot_q),
        .rd_valid (ent_v),
        .rd_owner (ent_o)
    );

    tdma_rr_pick #(.N_INIT(N_INIT), .ID_W(ID_W)) u_pick (
        .req  (req),
        .base (rr_q),
        .any  (rr_any),
        .win  (rr_win)
    );

    tdma_lat_timer #(.LAT_W(LAT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (go),
        .lat_cfg (lat_cfg),
        .last    (tmr_last)
    );

    always_comb begin
        arb_phase = (st_q == ST_ARB);
        own_ok    = ent_v && ({1'b0, ent_o} < (ID_W+1)'(N_INIT)) && req[ent_o];
        own_hit   = arb_phase && own_ok;
        contend   = arb_phase && !own_ok && rr_any;
        go        = own_hit || contend;
        win       = own_hit ? ent_o : rr_win;
        slot_nx   = (slot_q == SLOT_W'(N_SLOTS - 1)) ? '0 : slot_q + 1'b1;
        rr_nx     = (win == ID_W'(N_INIT - 1)) ? '0 : win + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_ARB;
            gnt_q  <= '0;
            slot_q <= '0;
            rr_q   <= '0;
        end else begin
            case (st_q)
                ST_ARB: begin
                    if (go) begin
                        st_q  <= ST_XFER;
                        gnt_q <= N_INIT'(1) << win;
                        if (contend) rr_q <= rr_nx;
                    end else begin
                        slot_q <= slot_nx;
                    end
                end
                ST_XFER: begin
                    if (tmr_last) begin
                        st_q   <= ST_ARB;
                        gnt_q  <= '0;
                        slot_q <= slot_nx;
                    end
                end
                default: st_q <= ST_ARB;
            endcase
        end
    end

    assign grant    = gnt_q;
    assign win_last = (st_q == ST_XFER) && tmr_last;

    // R7
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R5
    gnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && !win_last) |=> $stable(grant));

    // R5
    gnt_gap_chk: assert property (@(posedge clk) disable iff (rst)
        win_last |=> (grant == '0));

    // R2
    owner_win_chk: assert property (@(posedge clk) disable iff (rst)
        own_hit |=> grant[$past(ent_o)]);

    // R3
    contend_win_chk: assert property (@(posedge clk) disable iff (rst)
        contend |=> ((grant & $past(req)) != '0));

    // R4
    rr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        own_hit |=> $stable(rr_q));

    // R8
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (win_last || (arb_phase && req == '0)) |=>
            (slot_q == (($past(slot_q) == SLOT_W'(N_SLOTS - 1)) ? '0 : $past(slot_q) + 1'b1)));

    // R8
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && !win_last) |=> $stable(slot_q));

    // R6
    last_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        win_last |=> !win_last);

endmodule

// File: tb/sim_tdma_rr_arbiter.sv
`timescale 1ns/1ps
module sim_tdma_rr_arbiter;

    localparam int N  = 4;
    localparam int S  = 8;
    localparam int LW = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req;
    logic         map_we;
    logic [2:0]   map_idx;
    logic         map_valid;
    logic [1:0]   map_owner;
    logic [LW-1:0] lat_cfg;
    logic [N-1:0] grant;
    logic         win_last;

    always #10 clk = ~clk;

    tdma_rr_arbiter #(.N_INIT(N), .N_SLOTS(S), .LAT_W(LW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .map_we    (map_we),
        .map_idx   (map_idx),
        .map_valid (map_valid),
        .map_owner (map_owner),
        .lat_cfg   (lat_cfg),
        .grant     (grant),
        .win_last  (win_last)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // Requirement-level reference state
    bit    mv [S];
    int    mo [S];
    int    mptr = 0;
    int    mrr  = 0;
    bit    mbusy = 1'b0;
    int    mcnt = 0;
    int    mwin = 0;
    int    wr_prev = -1;
    string mtag = "R1";

    function automatic int clampb(int v);
        if (v < 2) return 2;
        if (v > 7) return 7;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [3:0] r, input bit we, input int wi,
                        input bit wv, input int wo, input int lat);
        bit own;
        bit any;
        int w;
        int idx;
        logic [31:0] eg;
        req       = r;
        map_we    = we;
        map_idx   = wi[2:0];
        map_valid = wv;
        map_owner = wo[1:0];
        lat_cfg   = lat[3:0];
        if (!mbusy) begin
            own = mv[mptr] && r[mo[mptr]];
            any = 1'b0;
            w   = 0;
            if (own) begin
                any  = 1'b1;
                w    = mo[mptr];
                mtag = "R2 R8";
            end else begin
                for (int k = 0; k < N; k++) begin
                    idx = (mrr + k) % N;
                    if (!any && r[idx]) begin
                        any = 1'b1;
                        w   = idx;
                    end
                end
                mtag = "R3 R4";
            end
            if (any && wr_prev == mptr) mtag = {mtag, " R9"};
            if (any) begin
                mbusy = 1'b1;
                mwin  = w;
                mcnt  = clampb(lat) - 1;
                if (!own) mrr = (w + 1) % N;
            end else begin
                mptr = (mptr + 1) % S;
                mtag = "R8";
            end
        end else begin
            mtag = "R5";
            if (mcnt == 0) begin
                mbusy = 1'b0;
                mptr  = (mptr + 1) % S;
            end else begin
                mcnt--;
            end
        end
        wr_prev = -1;
        if (we) begin
            mv[wi]  = wv;
            mo[wi]  = wo;
            wr_prev = wi;
        end
        @(negedge clk);
        eg = mbusy ? (32'd1 << mwin) : 32'd0;
        chk(mtag, 32'(grant), eg);
        chk("R6", 32'(win_last), 32'(mbusy && mcnt == 0));
        chk("R7", 32'($countones(grant) <= 1), 32'd1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < S; i++) begin
            mv[i] = 1'b0;
            mo[i] = 0;
        end
        rst = 1'b1;
        req = '0;
        map_we = 1'b0;
        map_idx = '0;
        map_valid = 1'b0;
        map_owner = '0;
        lat_cfg = 4'd2;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1", 32'(grant), 32'd0);
        chk("R1", 32'(win_last), 32'd0);
        rst = 1'b0;

        // R1: free table right after reset, request from 2 -> contention from rr 0
        step(4'b0100, 0, 0, 0, 0, 2);
        chk("R1", 32'(grant), 32'b0100);

        // Free table: round-robin over every request pattern
        for (int p = 1; p < 16; p++)
            for (int c = 0; c < 12; c++)
                step(4'(p), 0, 0, 0, 0, 2);

        // Program owners on even slots, odd slots free
        for (int i = 0; i < S; i++)
            step(4'b0000, 1, i, (i % 2) == 0, i % 4, 2);

        // Sweep latency settings and request patterns
        for (int l = 0; l < 16; l++)
            for (int p = 0; p < 16; p++)
                for (int c = 0; c < 3; c++)
                    step(4'(p), 0, 0, 0, 0, l);

        // R9: write the entry the pointer is about to reach
        while (mbusy) step(4'b0000, 0, 0, 0, 0, 3);
        step(4'b0000, 1, (mptr + 1) % S, 1, 3, 3);
        step(4'b1111, 0, 0, 0, 0, 3);
        chk("R9", 32'(grant), 32'b1000);
        // R9: a write during an open window leaves the grant alone
        step(4'b1111, 1, mptr, 1, 0, 3);
        chk("R9", 32'(grant), 32'b1000);

        // Mixed pseudo-random traffic with table updates
        for (int c = 0; c < 2000; c++) begin
            int r;
            r = int'($urandom % 16);
            step(4'(r), ($urandom % 4) == 0, int'($urandom % 8),
                 ($urandom % 2) == 1, int'($urandom % 4), int'($urandom % 16));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule